// File: doc/BRIEF.md
# Reorder Buffer Bank Power Controller

This block decides, once per epoch, whether the banked reorder buffer should grow, shrink or stay the same size. It also decides which bank is switched. Two event counters run through the epoch. One counts cycles in which the whole buffer was full. The other counts cycles in which the reference thread (the thread with the best committed-instructions-per-entry ratio, chosen elsewhere) had its in-flight instructions filling its whole allocation. When the epoch-end strobe arrives, the controller compares both counts with thresholds.

On upsizing, the lowest-index powered-off bank is switched on. The block then issues a one-cycle grant that hands that bank's entries to the reference thread. On downsizing, the controller picks a victim bank by how quickly it is expected to drain. The victim stops accepting dispatch at once. Its supply enable is kept until the bank reports empty, and only then is the supply removed. When the buffer is rarely full but the reference thread still fills its allocation, the controller changes nothing. The partitioner may then move entries between threads without changing power.

Each bank is in one of three states: ON, DRAINING or OFF. The supply switch of each bank is modelled as a single enable output per bank.

Top module: `rob_bank_pwr_ctrl`

## Requirements
- R1: After reset every bank has pwr_en=1 and disp_ok=1, and grant_valid=0.
- R2: The full count and the fill count of an epoch each include every cycle from the cycle after the previous epoch_end up to and including the cycle with epoch_end high. Both counts restart from zero after each epoch_end.
- R3: If the epoch's full count is at least FULL_THR and some bank is OFF, the lowest-index OFF bank has pwr_en=1 and disp_ok=1 from the cycle after the epoch_end edge. In that same cycle only, grant_valid=1, grant_tid equals ref_tid, grant_bank is that bank's index and grant_entries=BANK_ENTRIES.
- R4: A downsize starts only when the full count is below FULL_THR and the fill count is below FILL_THR. A fill count of FILL_THR or more leaves every bank unchanged.
- R5: The victim is taken from the ON banks in this class order: an empty bank (bank_empty=1); then a bank with bank_head=1 and bank_tail=0; then a non-empty bank with neither pointer; last, any bank with bank_tail=1.
- R6: Among victim candidates of the same class, the highest-index bank is chosen.
- R7: A victim's disp_ok falls in the cycle after the epoch_end edge while its pwr_en stays 1. pwr_en falls one cycle after the first clock edge at which the bank is DRAINING and bank_empty=1, and never while the bank holds instructions.
- R8: At most one bank is DRAINING at a time. A downsize decision made while a bank is draining is dropped.
- R9: A downsize is never started when only one bank is ON, so at least one bank always accepts dispatch.
- R10: An upsize request with no OFF bank changes nothing and produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epoch_end | input | 1 | Last cycle of the current epoch; the decision is taken at this edge |
| rob_full | input | 1 | The whole reorder buffer is occupied this cycle |
| ref_fill | input | 1 | The reference thread's in-flight instructions fill its allocation this cycle |
| ref_tid | input | TID_W | Index of the most efficient thread |
| bank_empty | input | NB | Per bank: no instruction resident |
| bank_head | input | NB | Per bank: holds at least one thread's head pointer |
| bank_tail | input | NB | Per bank: holds at least one thread's tail pointer |
| pwr_en | output | NB | Per bank supply enable (ON or DRAINING) |
| disp_ok | output | NB | Per bank dispatch permission (ON only) |
| grant_valid | output | 1 | One-cycle pulse: bank entries handed to a thread |
| grant_tid | output | TID_W | Thread receiving the entries |
| grant_bank | output | IDX_W | Bank that was switched on |
| grant_entries | output | ENT_W | Entries granted (BANK_ENTRIES during a grant, else 0) |

## Verification
Suppose the per-bank state were wrong, for example a bank stuck in DRAINING or dropped to OFF too early. The ports would show it one cycle after the faulty edge: either disp_ok low with no epoch decision behind it, or pwr_en falling while bank_empty is low. A wrong victim choice shows up in the very first cycle after epoch_end, because exactly one disp_ok bit falls and its position can be compared with the class order. A counter that fails to clear or that misses the epoch_end cycle only shows up at the next threshold boundary. The bench therefore drives counts of exactly the threshold and exactly one below it across consecutive epochs.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  typedef enum logic [1:0] {
    BK_ON    = 2'd0,
    BK_DRAIN = 2'd1,
    BK_OFF   = 2'd2
  } bank_st_e;

  // Larger code = preferred victim (shorter expected drain latency).
  typedef enum logic [1:0] {
    VC_TAIL  = 2'd0,
    VC_IDLE  = 2'd1,
    VC_HEAD  = 2'd2,
    VC_EMPTY = 2'd3
  } vict_cls_e;

  function automatic vict_cls_e classify(input logic empty, input logic head, input logic tail);
    if (empty)      return VC_EMPTY;
    else if (tail)  return VC_TAIL;
    else if (head)  return VC_HEAD;
    else            return VC_IDLE;
  endfunction
endpackage

// File: rtl/rbp_epoch_ctr.sv
module rbp_epoch_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] total
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    total = (cnt_q == {W{1'b1}}) ? cnt_q : cnt_q + W'(inc);
    cnt_d = clr ? '0 : total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/rbp_victim_sel.sv
module rbp_victim_sel
  import rbp_pkg::*;
#(
  parameter int NB    = 8,
  parameter int IDX_W = $clog2(NB)
) (
  input  logic [NB-1:0]    cand,
  input  logic [NB-1:0]    empty,
  input  logic [NB-1:0]    head,
  input  logic [NB-1:0]    tail,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  vict_cls_e best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = VC_TAIL;
    // ascending scan with >= lets the higher index win a tie
    for (int i = 0; i < NB; i++) begin
      if (cand[i] && (!found || (classify(empty[i], head[i], tail[i]) >= best))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = classify(empty[i], head[i], tail[i]);
      end
    end
  end

  // R5
  victim_is_cand_chk: assert final (!found || cand[idx]);
endmodule

// File: rtl/rbp_bank.sv
module rbp_bank
  import rbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic turn_on,
  input  logic turn_off,
  input  logic empty,
  output logic pwr_en,
  output logic disp_ok,
  output logic is_on,
  output logic is_drain,
  output logic is_off
);
  bank_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BK_ON:    if (turn_off) st_d = BK_DRAIN;
      BK_DRAIN: if (empty)    st_d = BK_OFF;
      BK_OFF:   if (turn_on)  st_d = BK_ON;
      default:  st_d = BK_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BK_ON;
    else        st_q <= st_d;
  end

  assign is_on    = (st_q == BK_ON);
  assign is_drain = (st_q == BK_DRAIN);
  assign is_off   = (st_q == BK_OFF);
  assign pwr_en   = !is_off;
  assign disp_ok  = is_on;

  // R7
  off_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(empty));
  // R3
  on_only_by_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_ok) |-> $past(turn_on));
endmodule

// File: rtl/rob_bank_pwr_ctrl.sv
module rob_bank_pwr_ctrl #(
  parameter int NB           = 8,
  parameter int NT           = 4,
  parameter int BANK_ENTRIES = 16,
  parameter int CNT_W        = 12,
  parameter int FULL_THR     = 16,
  parameter int FILL_THR     = 4,
  parameter int TID_W        = $clog2(NT),
  parameter int IDX_W        = $clog2(NB),
  parameter int ENT_W        = $clog2(BANK_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epoch_end,
  input  logic             rob_full,
  input  logic             ref_fill,
  input  logic [TID_W-1:0] ref_tid,
  input  logic [NB-1:0]    bank_empty,
  input  logic [NB-1:0]    bank_head,
  input  logic [NB-1:0]    bank_tail,
  output logic [NB-1:0]    pwr_en,
  output logic [NB-1:0]    disp_ok,
  output logic             grant_valid,
  output logic [TID_W-1:0] grant_tid,
  output logic [IDX_W-1:0] grant_bank,
  output logic [ENT_W-1:0] grant_entries
);
  localparam int ONC_W = $clog2(NB + 1);

  logic [CNT_W-1:0] full_tot, fill_tot;
  logic [NB-1:0]    is_on, is_drain, is_off, turn_on, turn_off;
  logic             vic_found, off_any, drain_any, up_go, dn_go;
  logic [IDX_W-1:0] vic_idx, on_idx;
  logic [ONC_W-1:0] on_cnt;

  logic             gv_q, gv_d;
  logic [TID_W-1:0] gt_q, gt_d;
  logic [IDX_W-1:0] gb_q, gb_d;

  rbp_epoch_ctr #(.W(CNT_W)) u_full_ctr (
    .clk(clk), .rst_n(rst_n), .inc(rob_full), .clr(epoch_end), .total(full_tot));
  rbp_epoch_ctr #(.W(CNT_W)) u_fill_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ref_fill), .clr(epoch_end), .total(fill_tot));

  rbp_victim_sel #(.NB(NB), .IDX_W(IDX_W)) u_vsel (
    .cand(is_on), .empty(bank_empty), .head(bank_head), .tail(bank_tail),
    .found(vic_found), .idx(vic_idx));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    rbp_bank u_bank (
      .clk(clk), .rst_n(rst_n), .turn_on(turn_on[b]), .turn_off(turn_off[b]),
      .empty(bank_empty[b]), .pwr_en(pwr_en[b]), .disp_ok(disp_ok[b]),
      .is_on(is_on[b]), .is_drain(is_drain[b]), .is_off(is_off[b]));
  end

  always_comb begin
    off_any = 1'b0;
    on_idx  = '0;
    on_cnt  = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (is_off[i]) begin
        off_any = 1'b1;
        on_idx  = IDX_W'(i);
      end
    end
    for (int i = 0; i < NB; i++) on_cnt = on_cnt + ONC_W'(is_on[i]);
  end

  assign drain_any = |is_drain;

  always_comb begin
    up_go = epoch_end && (full_tot >= CNT_W'(FULL_THR)) && off_any;
    dn_go = epoch_end && (full_tot <  CNT_W'(FULL_THR)) && (fill_tot < CNT_W'(FILL_THR))
            && !drain_any && (on_cnt >= ONC_W'(2)) && vic_found;
    turn_on  = up_go ? (NB'(1) << on_idx)  : '0;
    turn_off = dn_go ? (NB'(1) << vic_idx) : '0;
    gv_d = up_go;
    gt_d = up_go ? ref_tid : gt_q;
    gb_d = up_go ? on_idx  : gb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q <= 1'b0;
      gt_q <= '0;
      gb_q <= '0;
    end else begin
      gv_q <= gv_d;
      gt_q <= gt_d;
      gb_q <= gb_d;
    end
  end

  assign grant_valid   = gv_q;
  assign grant_tid     = gt_q;
  assign grant_bank    = gb_q;
  assign grant_entries = gv_q ? ENT_W'(BANK_ENTRIES) : '0;

  // R8
  one_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(is_drain));
  // R9
  last_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_ok) >= 1);
  // R3
  grant_after_epoch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(epoch_end));
  // R3
  grant_bank_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> disp_ok[grant_bank]);
endmodule

// File: tb/test_rob_bank_pwr_ctrl.sv
module test_rob_bank_pwr_ctrl;
  localparam int NB = 8, NT = 4, BE = 16, CW = 12, FT = 16, LT = 4;
  localparam int TW = $clog2(NT), IW = $clog2(NB), EW = $clog2(BE + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic epoch_end = 1'b0, rob_full = 1'b0, ref_fill = 1'b0;
  logic [TW-1:0] ref_tid = '0;
  logic [NB-1:0] bank_empty = '0, bank_head = '0, bank_tail = '0;
  logic [NB-1:0] pwr_en, disp_ok;
  logic grant_valid;
  logic [TW-1:0] grant_tid;
  logic [IW-1:0] grant_bank;
  logic [EW-1:0] grant_entries;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  rob_bank_pwr_ctrl #(.NB(NB), .NT(NT), .BANK_ENTRIES(BE), .CNT_W(CW),
                      .FULL_THR(FT), .FILL_THR(LT)) i_rob_bank_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .epoch_end(epoch_end), .rob_full(rob_full),
    .ref_fill(ref_fill), .ref_tid(ref_tid), .bank_empty(bank_empty),
    .bank_head(bank_head), .bank_tail(bank_tail), .pwr_en(pwr_en),
    .disp_ok(disp_ok), .grant_valid(grant_valid), .grant_tid(grant_tid),
    .grant_bank(grant_bank), .grant_entries(grant_entries));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_epoch(input int nfull, input int nfill, input int len);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      rob_full  = (c < nfull);
      ref_fill  = (c < nfill);
      epoch_end = (c == len - 1);
    end
    @(negedge clk);
    rob_full = 1'b0; ref_fill = 1'b0; epoch_end = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "pwr_en", pwr_en, 8'hFF);
    chk("R1", "disp_ok", disp_ok, 8'hFF);
    chk("R1", "grant_valid", grant_valid, 0);
  endtask

  task automatic t_down_empty();
    bank_empty = 8'b0010_0100;
    run_epoch(0, 0, 4);
    chk("R5", "empty victim disp_ok", disp_ok, 8'hDF);
    chk("R7", "draining keeps power", pwr_en, 8'hFF);
    chk("R4", "no grant on downsize", grant_valid, 0);
    @(negedge clk);
    chk("R7", "drained bank off", pwr_en, 8'hDF);
  endtask

  task automatic t_blocked();
    bank_empty = '0;
    run_epoch(0, LT, 8);
    chk("R4", "fill at threshold blocks", disp_ok, 8'hDF);
    run_epoch(FT - 1, LT, 20);
    chk("R4", "below full thr no change", pwr_en, 8'hDF);
    chk("R3", "no grant below thr", grant_valid, 0);
  endtask

  task automatic t_head();
    bank_head = 8'b0000_1010; bank_tail = 8'b1100_1000;
    run_epoch(0, LT - 1, 4);
    chk("R5", "head-only victim", disp_ok, 8'hDD);
    chk("R7", "head victim powered", pwr_en, 8'hDF);
    bank_empty = 8'b0001_0000;
    run_epoch(0, 0, 4);
    chk("R8", "second drain refused", disp_ok, 8'hDD);
    bank_head = 8'b0000_1000; bank_empty = 8'b0001_0010;
    @(negedge clk);
    chk("R7", "head victim off when empty", pwr_en, 8'hDD);
    chk("R8", "bank4 untouched", disp_ok, 8'hDD);
  endtask

  task automatic t_idle();
    bank_empty = '0;
    run_epoch(0, 0, 4);
    chk("R6", "highest idle bank", disp_ok, 8'hCD);
    bank_empty = 8'h10;
    @(negedge clk); @(negedge clk);
    chk("R7", "idle victim off", pwr_en, 8'hCD);
  endtask

  task automatic t_tail();
    bank_empty = '0; bank_head = '0; bank_tail = 8'b1100_1101;
    run_epoch(0, 0, 4);
    chk("R6", "highest tail bank", disp_ok, 8'h4D);
    chk("R7", "tail victim powered", pwr_en, 8'hCD);
    bank_empty = 8'h80;
    @(negedge clk); @(negedge clk);
    chk("R7", "tail victim off", pwr_en, 8'h4D);
  endtask

  task automatic t_up();
    bank_empty = '0; bank_tail = '0; ref_tid = 2'd2;
    run_epoch(FT, 0, FT);
    chk("R3", "grant_valid", grant_valid, 1);
    chk("R3", "grant_tid", grant_tid, 2);
    chk("R3", "grant_bank lowest off", grant_bank, 1);
    chk("R3", "grant_entries", grant_entries, BE);
    chk("R3", "bank1 on", pwr_en, 8'h4F);
    chk("R2", "epoch_end cycle counted", disp_ok, 8'h4F);
    @(negedge clk);
    chk("R3", "grant one cycle", grant_valid, 0);
  endtask

  task automatic t_clear();
    run_epoch(10, 9, 10);
    run_epoch(10, 9, 10);
    chk("R2", "counter cleared per epoch", grant_valid, 0);
    chk("R2", "state unchanged", pwr_en, 8'h4F);
  endtask

  task automatic t_last();
    bank_empty = 8'hFF;
    for (int k = 0; k < 10; k++) begin
      run_epoch(0, 0, 2);
      @(negedge clk);
    end
    chk("R9", "one bank left powered", pwr_en, 8'h01);
    chk("R9", "one bank left dispatching", disp_ok, 8'h01);
  endtask

  task automatic t_refill();
    ref_tid = 2'd1;
    for (int k = 0; k < 7; k++) begin
      run_epoch(FT, 0, FT);
      chk("R3", "refill grant", grant_valid, 1);
      if (k == 6) chk("R3", "last refill bank", grant_bank, 7);
    end
    chk("R10", "all banks on", pwr_en, 8'hFF);
    run_epoch(FT + 4, 0, FT + 4);
    chk("R10", "no grant when none off", grant_valid, 0);
    chk("R10", "dispatch unchanged", disp_ok, 8'hFF);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_down_empty();
    t_blocked();
    t_head();
    t_idle();
    t_tail();
    t_up();
    t_clear();
    t_last();
    t_refill();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule